// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM Core

This block is a synthesizable model of a synchronous static RAM with a 32-bit word split into four byte lanes and a depth set by a parameter. An access begins when one of two address strobes is sampled low. The strobes are a processor-side strobe and a controller-side strobe. The address presented on that edge is loaded into a base register, and an internal 2-bit beat counter is cleared. On each following clock in which the advance input is low, the counter steps once. The low two address bits then follow either a linear or an interleaved four-beat order, so one address can yield four data words.

Reads are registered twice. The access address is captured on the edge that starts or continues the beat. The array word is captured on the next edge. This gives a 3-1-1-1 pattern for a four-beat burst. Writes are decided on every active cycle from three controls: a global write, a byte-write enable, and four per-lane selects. Data comes in on a separate input bus and goes out on a separate output bus, with a valid flag.

The output enable and the sleep input act on the outputs without waiting for a clock. Sleep also parks the controller in a doze state, where no access is started or continued.

The controller is a three-state machine:
- IDLE: no burst is open.
- BURST: a base address is loaded, and beats continue from it.
- DOZE: sleep is held.

Its transitions are:
- start: IDLE, BURST or DOZE to BURST, on a strobe with the chip fully selected.
- drop: any state to IDLE, on a strobe with the chip not fully selected.
- beat: BURST to BURST, with no strobe.
- nap: any state to DOZE, whenever sleep is high.
- wake: DOZE to IDLE, when sleep is low and no strobe is present.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset, `rvalid` is 0 and `rdata` is 0 while `oe_n` is low.
- R2: A processor-strobe start (`strb_cpu_n`=0 with `ce_n`=0 and the chip fully selected) loads `addr` and performs a read of that word, whatever `gw_n`, `bwe_n` and `bw_n` are. The processor strobe has priority over the controller strobe.
- R3: The processor strobe is ignored when `ce_n` is 1: from IDLE with no controller strobe, no access takes place and no read data is produced.
- R4: A controller-strobe start (`strb_ctl_n`=0) always samples the selects. The chip is fully selected when `ce_n`=0, `cs_hi`=1 and `cs_lo_n`=0. If it is not fully selected, no access occurs and the machine goes to IDLE.
- R5: On every access cycle except a processor-strobe start, the write lanes are decoded as follows. If `gw_n`=0, all four lanes are written. Otherwise, if `bwe_n`=0, lane i is written when `bw_n[i]`=0, where lane i is data bits 8i+7 to 8i. If no lane is selected, the cycle is a read. Unwritten lanes keep their contents.
- R6: In BURST, with no strobe, `adv_n`=0 steps the 2-bit beat counter by one, wrapping modulo 4. `adv_n`=1 holds the counter, so the same word is accessed again.
- R7: With `order_lin`=1, the low two address bits of a beat are the start bits plus the counter, modulo 4.
- R8: With `order_lin`=0, the low two address bits of a beat are the start bits XOR the counter.
- R9: A read issued on clock edge k presents its word on `rdata`, with `rvalid`=1, after edge k+1. A write on edge k is visible to a read issued on edge k+1.
- R10: A deselecting strobe on edge k leaves `rvalid` low after edge k+1 and stops any burst in progress.
- R11: `oe_n`=1 forces `rdata` to 0 and `rvalid` to 0 without waiting for a clock edge.
- R12: While `sleep` is 1, `rvalid` is 0 at once, strobes are ignored, and the machine enters DOZE. After sleep ends, a burst does not resume without a new start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address, loaded on a start |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Chip enable, active low |
| cs_hi | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| order_lin | input | 1 | 1 selects linear beat order, 0 selects interleaved |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 4 | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Sleep request, active high |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data |
| rvalid | output | 1 | Read data valid |

## Verification
The bench builds the block with `ADDR_W` set to 5, which gives a 32-word array. The whole array is filled by eight linear write bursts, so every later read has a known expected value. Random addresses then land on the same words often. This makes read-after-write across the pipeline, partial lane writes over older data, and interleaved and wrapped beat sequences frequent events, not rare ones. The same setting keeps the base-address upper bits narrow enough that bursts from different starts overlap.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_DOZE  = 2'd2
    } sbs_state_e;

    typedef enum logic [1:0] {
        L_NONE = 2'd0,
        L_CPU  = 2'd1,
        L_CTL  = 2'd2,
        L_DROP = 2'd3
    } sbs_launch_e;

    // low two address bits of a beat, from its start bits and beat count
    function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                           input logic [1:0] cnt,
                                           input logic       lin);
        return lin ? (start + cnt) : (start ^ cnt);
    endfunction

endpackage

// File: rtl/sbs_wr_decode.sv
module sbs_wr_decode
    import sbs_pkg::*;
(
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output logic [LANES-1:0] lane_we
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_we[g] = !gw_n || (!bwe_n && !bw_n[g]);
    end

endmodule

// File: rtl/sbs_burst_ctrl.sv
module sbs_burst_ctrl
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              strb_cpu_n,
    input  logic              strb_ctl_n,
    input  logic              adv_n,
    input  logic              ce_n,
    input  logic              cs_hi,
    input  logic              cs_lo_n,
    input  logic              order_lin,
    input  logic              sleep,
    input  logic [LANES-1:0]  lane_we,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              acc_rd,
    output logic [LANES-1:0]  acc_wmask
);

    sbs_state_e        state_q, state_d;
    sbs_launch_e       launch;
    logic [ADDR_W-1:0] base_q, base_d;
    logic [1:0]        cnt_q, cnt_d;
    logic              sel_ok, cpu_go, ctl_go;

    assign sel_ok = !ce_n && cs_hi && !cs_lo_n;
    assign cpu_go = !strb_cpu_n && !ce_n;
    assign ctl_go = !strb_ctl_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            base_q  <= base_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state: sleep first, then strobes, then burst continuation
    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        cnt_d   = cnt_q;
        launch  = L_NONE;
        if (sleep) begin
            state_d = ST_DOZE;
        end else if (cpu_go || ctl_go) begin
            if (sel_ok) begin
                launch  = cpu_go ? L_CPU : L_CTL;
                state_d = ST_BURST;
                base_d  = addr;
                cnt_d   = '0;
            end else begin
                launch  = L_DROP;
                state_d = ST_IDLE;
            end
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_DOZE:  state_d = ST_IDLE;
                ST_BURST: if (!adv_n) cnt_d = cnt_q + 2'd1;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // outputs: the access performed on this edge
    always_comb begin
        acc_addr  = addr;
        acc_rd    = 1'b0;
        acc_wmask = '0;
        unique case (launch)
            L_CPU: acc_rd = 1'b1;
            L_CTL: begin
                if (|lane_we) acc_wmask = lane_we;
                else          acc_rd    = 1'b1;
            end
            L_DROP: acc_rd = 1'b0;
            L_NONE: begin
                if (!sleep && state_q == ST_BURST) begin
                    acc_addr = {base_q[ADDR_W-1:2], beat_lo(base_q[1:0], cnt_d, order_lin)};
                    if (|lane_we) acc_wmask = lane_we;
                    else          acc_rd    = 1'b1;
                end
            end
            default: acc_rd = 1'b0;
        endcase
    end

    assert_cpu_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_go && !sleep) |-> (acc_wmask == '0));

    assert_drop_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_go && !cpu_go && !sleep && !sel_ok) |=> (state_q == ST_IDLE));

    assert_hold_cnt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BURST && !sleep && !cpu_go && !ctl_go && adv_n) |=> $stable(cnt_q));

    assert_step_cnt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BURST && !sleep && !cpu_go && !ctl_go && !adv_n)
        |=> (cnt_q == $past(cnt_q) + 2'd1));

    assert_doze_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (state_q == ST_DOZE));

endmodule

// File: rtl/sbs_array_pipe.sv
module sbs_array_pipe
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_rd,
    input  logic [LANES-1:0]  acc_wmask,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] dout_q,
    output logic              vld_q
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] bit_mask;
    logic [ADDR_W-1:0] rd_addr_q;
    logic              rd_q;

    for (genvar g = 0; g < LANES; g++) begin : g_mask
        assign bit_mask[g*LANE_W +: LANE_W] = {LANE_W{acc_wmask[g]}};
    end

    always_ff @(posedge clk) begin
        if (|acc_wmask)
            mem[acc_addr] <= (mem[acc_addr] & ~bit_mask) | (wdata & bit_mask);
    end

    // stage 1 captures the read address, stage 2 captures the word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q      <= 1'b0;
            rd_addr_q <= '0;
            vld_q     <= 1'b0;
            dout_q    <= '0;
        end else begin
            rd_q      <= acc_rd;
            rd_addr_q <= acc_addr;
            vld_q     <= rd_q;
            if (rd_q) dout_q <= mem[rd_addr_q];
        end
    end

    assert_rd_wr_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_rd && (acc_wmask != '0)));

    assert_pipe_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q |=> vld_q);

    assert_no_read_no_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_q |=> !vld_q);

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              strb_cpu_n,
    input  logic              strb_ctl_n,
    input  logic              adv_n,
    input  logic              ce_n,
    input  logic              cs_hi,
    input  logic              cs_lo_n,
    input  logic              order_lin,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [3:0]        bw_n,
    input  logic              oe_n,
    input  logic              sleep,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              rvalid
);

    logic [LANES-1:0]  lane_we;
    logic [ADDR_W-1:0] acc_addr;
    logic              acc_rd;
    logic [LANES-1:0]  acc_wmask;
    logic [WORD_W-1:0] dout_q;
    logic              vld_q;

    sbs_wr_decode u_dec (
        .gw_n    (gw_n),
        .bwe_n   (bwe_n),
        .bw_n    (bw_n),
        .lane_we (lane_we)
    );

    sbs_burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .strb_cpu_n (strb_cpu_n),
        .strb_ctl_n (strb_ctl_n),
        .adv_n      (adv_n),
        .ce_n       (ce_n),
        .cs_hi      (cs_hi),
        .cs_lo_n    (cs_lo_n),
        .order_lin  (order_lin),
        .sleep      (sleep),
        .lane_we    (lane_we),
        .acc_addr   (acc_addr),
        .acc_rd     (acc_rd),
        .acc_wmask  (acc_wmask)
    );

    sbs_array_pipe #(.ADDR_W(ADDR_W)) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_addr  (acc_addr),
        .acc_rd    (acc_rd),
        .acc_wmask (acc_wmask),
        .wdata     (wdata),
        .dout_q    (dout_q),
        .vld_q     (vld_q)
    );

    assign rdata  = oe_n ? '0 : dout_q;
    assign rvalid = vld_q && !oe_n && !sleep;

endmodule

// File: tb/sync_burst_sram_tb.sv
module sync_burst_sram_tb;

    localparam int AW    = 5;
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [AW-1:0] a;
        logic cpu_n, ctl_n, adv_n, ce_n, cs_hi, cs_lo_n, lin;
        logic gw_n, bwe_n;
        logic [3:0] bw_n;
        logic oe_n, sleep;
        logic [31:0] wd;
    } drv_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] addr;
    logic strb_cpu_n, strb_ctl_n, adv_n, ce_n, cs_hi, cs_lo_n, order_lin;
    logic gw_n, bwe_n, oe_n, sleep;
    logic [3:0] bw_n;
    logic [31:0] wdata, rdata;
    logic rvalid;

    int n_chk = 0;
    int n_bad = 0;

    // reference state
    logic [31:0] m_mem [DEPTH];
    int          m_st = 0;            // 0 idle, 1 burst, 2 doze
    logic [AW-1:0] m_base = '0;
    logic [1:0]  m_cnt = '0;
    bit          e0_v = 0, e1_v = 0;
    logic [31:0] e0_d = '0, e1_d = '0;
    string       e0_t = "R9", e1_t = "R9";
    string       cur_tag = "R9";

    always #5 clk = ~clk;

    sync_burst_sram #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .strb_cpu_n(strb_cpu_n),
        .strb_ctl_n(strb_ctl_n), .adv_n(adv_n), .ce_n(ce_n), .cs_hi(cs_hi),
        .cs_lo_n(cs_lo_n), .order_lin(order_lin), .gw_n(gw_n), .bwe_n(bwe_n),
        .bw_n(bw_n), .oe_n(oe_n), .sleep(sleep), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid)
    );

    task automatic chk(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    function automatic drv_t idle_drv();
        drv_t d;
        d = '0;
        d.cpu_n = 1; d.ctl_n = 1; d.adv_n = 1; d.ce_n = 0; d.cs_hi = 1; d.cs_lo_n = 0;
        d.lin = 1; d.gw_n = 1; d.bwe_n = 1; d.bw_n = 4'hF; d.oe_n = 0; d.sleep = 0;
        return d;
    endfunction

    function automatic logic [1:0] exp_lo(input logic [1:0] s, input logic [1:0] c, input logic lin);
        logic [1:0] r;
        if (lin) r = s + c;        // R7
        else     r = s ^ c;        // R8
        return r;
    endfunction

    function automatic logic [3:0] exp_lanes(input drv_t d);
        logic [3:0] m;
        for (int i = 0; i < 4; i++) m[i] = !d.gw_n || (!d.bwe_n && !d.bw_n[i]);   // R5
        return m;
    endfunction

    task automatic apply(input drv_t d);
        addr = d.a; strb_cpu_n = d.cpu_n; strb_ctl_n = d.ctl_n; adv_n = d.adv_n;
        ce_n = d.ce_n; cs_hi = d.cs_hi; cs_lo_n = d.cs_lo_n; order_lin = d.lin;
        gw_n = d.gw_n; bwe_n = d.bwe_n; bw_n = d.bw_n; oe_n = d.oe_n;
        sleep = d.sleep; wdata = d.wd;
    endtask

    task automatic do_access(input logic [AW-1:0] a, input logic [3:0] m, input logic [31:0] wd,
                             output bit rd, output logic [31:0] rv);
        logic [31:0] bm;
        rd = 0; rv = '0;
        if (m != 0) begin
            for (int i = 0; i < 4; i++) bm[i*8 +: 8] = {8{m[i]}};
            m_mem[a] = (m_mem[a] & ~bm) | (wd & bm);
        end else begin
            rd = 1; rv = m_mem[a];
        end
    endtask

    task automatic model(input drv_t d, output bit rd, output logic [31:0] rv);
        bit sel;
        logic [AW-1:0] a;
        rd = 0; rv = '0;
        sel = !d.ce_n && d.cs_hi && !d.cs_lo_n;
        if (d.sleep) begin
            m_st = 2;                                              // R12
        end else if (!d.cpu_n && !d.ce_n) begin
            if (sel) begin
                m_st = 1; m_base = d.a; m_cnt = 0; rd = 1; rv = m_mem[d.a];   // R2
            end else m_st = 0;
        end else if (!d.ctl_n) begin
            if (sel) begin
                m_st = 1; m_base = d.a; m_cnt = 0;
                do_access(d.a, exp_lanes(d), d.wd, rd, rv);
            end else m_st = 0;                                     // R4
        end else if (m_st == 1) begin
            if (!d.adv_n) m_cnt = m_cnt + 2'd1;                    // R6
            a = {m_base[AW-1:2], exp_lo(m_base[1:0], m_cnt, d.lin)};
            do_access(a, exp_lanes(d), d.wd, rd, rv);
        end else begin
            m_st = 0;
        end
    endtask

    // check the read issued two drives ago, then drive the next cycle
    task automatic tick(input drv_t d);
        bit rd;
        logic [31:0] rv;
        bit exp_v;
        @(negedge clk);
        exp_v = e1_v && !oe_n && !sleep;
        chk(rvalid == exp_v, {e1_t, " rvalid"}, {31'b0, rvalid}, {31'b0, exp_v});
        if (exp_v) chk(rdata == e1_d, {e1_t, " rdata"}, rdata, e1_d);
        if (oe_n)  chk(rdata == 32'b0, "R11 rdata gated", rdata, 32'b0);
        apply(d);
        model(d, rd, rv);
        e1_v = e0_v; e1_d = e0_d; e1_t = e0_t;
        e0_v = rd;   e0_d = rv;   e0_t = cur_tag;
    endtask

    task automatic flush();
        repeat (3) tick(idle_drv());
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        drv_t d;
        void'($urandom(32'd7));
        apply(idle_drv());
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rvalid == 1'b0, "R1 rvalid after reset", {31'b0, rvalid}, 32'b0);
        chk(rdata == 32'b0, "R1 rdata after reset", rdata, 32'b0);

        // fill the array with linear write bursts (R5, R6, R7)
        cur_tag = "R5";
        for (int b = 0; b < DEPTH / 4; b++) begin
            for (int k = 0; k < 4; k++) begin
                d = idle_drv();
                d.gw_n = 0;
                d.wd = 32'hA500_0000 | (b << 8) | k;
                if (k == 0) begin d.ctl_n = 0; d.a = AW'(4 * b); end
                else d.adv_n = 0;
                tick(d);
            end
        end

        // linear read burst from an odd start: 1,2,3,0 (R7)
        cur_tag = "R7";
        d = idle_drv(); d.ctl_n = 0; d.a = 5'd9; tick(d);
        for (int k = 0; k < 3; k++) begin d = idle_drv(); d.adv_n = 0; tick(d); end
        flush();

        // interleaved read burst from start 2: 2,3,0,1 (R8)
        cur_tag = "R8";
        d = idle_drv(); d.lin = 0; d.cpu_n = 0; d.a = 5'd14; tick(d);
        for (int k = 0; k < 3; k++) begin d = idle_drv(); d.lin = 0; d.adv_n = 0; tick(d); end
        flush();

        // advance held high repeats the same word (R6)
        cur_tag = "R6";
        d = idle_drv(); d.ctl_n = 0; d.a = 5'd7; tick(d);
        d = idle_drv(); tick(d);
        d = idle_drv(); d.adv_n = 0; tick(d);
        d = idle_drv(); tick(d);
        flush();

        // processor start ignores write controls (R2)
        cur_tag = "R2";
        d = idle_drv(); d.cpu_n = 0; d.gw_n = 0; d.wd = 32'hDEAD_BEEF; d.a = 5'd3; tick(d);
        flush();

        // byte write of lanes 0 and 2, then read back (R5)
        cur_tag = "R5";
        d = idle_drv(); d.ctl_n = 0; d.bwe_n = 0; d.bw_n = 4'b1010; d.a = 5'd20;
        d.wd = 32'h1122_3344; tick(d);
        d = idle_drv(); d.ctl_n = 0; d.bw_n = 4'b0000; d.a = 5'd20; tick(d);   // bwe_n high: read
        flush();

        // processor strobe with chip enable off is ignored (R3)
        cur_tag = "R3";
        d = idle_drv(); d.cpu_n = 0; d.ce_n = 1; d.a = 5'd2; tick(d);
        flush();

        // controller start not selected (R4) and deselect mid burst (R10)
        cur_tag = "R4";
        d = idle_drv(); d.ctl_n = 0; d.cs_hi = 0; d.a = 5'd4; tick(d);
        flush();
        cur_tag = "R10";
        d = idle_drv(); d.ctl_n = 0; d.a = 5'd16; tick(d);
        d = idle_drv(); d.ctl_n = 0; d.cs_lo_n = 1; tick(d);
        d = idle_drv(); d.adv_n = 0; tick(d);
        flush();

        // output enable gates at once (R11)
        cur_tag = "R11";
        d = idle_drv(); d.ctl_n = 0; d.a = 5'd12; tick(d);
        d = idle_drv(); d.adv_n = 0; tick(d);
        d = idle_drv(); d.adv_n = 0; d.oe_n = 1; tick(d);
        #1;
        chk(rdata == 32'b0 && rvalid == 1'b0, "R11 immediate gating", rdata, 32'b0);
        flush();

        // sleep: valid low at once, burst does not resume (R12)
        cur_tag = "R12";
        d = idle_drv(); d.ctl_n = 0; d.a = 5'd24; tick(d);
        d = idle_drv(); d.adv_n = 0; d.sleep = 1; tick(d);
        #1;
        chk(rvalid == 1'b0, "R12 sleep gates valid", {31'b0, rvalid}, 32'b0);
        d = idle_drv(); d.sleep = 1; d.ctl_n = 0; d.a = 5'd1; tick(d);
        d = idle_drv(); d.adv_n = 0; tick(d);
        d = idle_drv(); d.adv_n = 0; tick(d);
        flush();

        // constrained random traffic (R9 and all controls mixed)
        cur_tag = "R9";
        begin
            logic lin_r;
            lin_r = 1;
            for (int i = 0; i < 3000; i++) begin
                int r;
                if (i % 250 == 0) lin_r = ~lin_r;
                d = idle_drv();
                r = $urandom % 100;
                d.cpu_n   = !(r < 12);
                d.ctl_n   = !(r >= 12 && r < 26);
                d.a       = AW'($urandom);
                d.ce_n    = ($urandom % 10 == 0);
                d.cs_hi   = ($urandom % 12 != 0);
                d.cs_lo_n = ($urandom % 12 == 0);
                d.adv_n   = ($urandom % 10 < 3);
                d.gw_n    = ($urandom % 7 != 0);
                d.bwe_n   = ($urandom % 4 != 0);
                d.bw_n    = 4'($urandom);
                d.oe_n    = ($urandom % 20 == 0);
                d.sleep   = ($urandom % 40 == 0);
                d.lin     = lin_r;
                d.wd      = $urandom;
                tick(d);
            end
        end
        flush();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule